// File: doc/BRIEF.md
# Single-Cycle Processor Core with Call and Indirect Jumps

This block is a 32-bit processor core that finishes one instruction in every clock cycle. On each cycle it fetches a word from an instruction memory, decodes it and reads two operands from a 32-entry register file. It then runs the arithmetic unit and, when the instruction needs it, accesses a data memory. At the next rising edge it commits both the register result and the next program counter. Both memories sit outside the core. Each is byte-addressed and returns a whole word with no wait states, combinationally.

Beyond the usual arithmetic, load, store, compare-branch and jump set, the core supports three more operations. A call jump saves the return address in register 31. A register-indexed load adds two registers to form its address. An indirect jump takes the next program counter from a word in data memory. To support these, three datapath selects are 2 bits wide: the destination register choice, the write-back source, and the next-PC source.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register reads back as 0 afterwards.
- R2: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x2A writes rs+rt, rs−rt, rs&rt, rs|rt, or the signed rs<rt flag (1 or 0) into rd. It then advances the program counter by 4.
- R3: Opcode 0x23 writes the data-memory word at rs + sign-extended imm16 (bits 15:0) into rt (bits 20:16).
- R4: Opcode 0x2B writes rt to the data-memory word at rs + sign-extended imm16 and changes no register. In that cycle the write strobe is high and the read strobe is low.
- R5: Opcode 0x04 compares rs with rt. If they are equal, the next program counter is PC+4 + (sign-extended imm16 << 2). Otherwise it is PC+4.
- R6: Opcode 0x02 sets the program counter to {PC+4[31:28], bits 25:0, 2'b00}.
- R7: Opcode 0x03 jumps to the same target as R6 and writes PC+4 into register 31.
- R8: Opcode 0x00 with funct 0x30 writes the data-memory word at rs+rt into rd. This holds when rd equals rs or rt.
- R9: Opcode 0x38 loads the program counter from the data-memory word at rs + sign-extended imm16. It writes no register, even when the rt field is nonzero.
- R10: Register 0 always reads as zero. Writes aimed at it are discarded.
- R11: The data-memory read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction being executed (program counter) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for the data access |
| dmem_re | output | 1 | Data read strobe |
| dmem_we | output | 1 | Data write strobe, committed at the rising edge |
| dmem_wdata | output | 32 | Word to store |
| dmem_rdata | input | 32 | Word read at `dmem_addr` |

## Verification
A register read and a register write can fall in the same cycle. This happens when a load names its own address register as the destination, or when the register-indexed load writes over one of its two index registers. Three directed programs exercise this: `lw r4,0(r4)`, an indexed load whose rd equals both sources, and a discarded write to register 0 while register 0 is read. Each result is stored to data memory, and the bench judges it against a value computed from the memory image it preloaded, so the old operand is shown to have produced the address. A second overlap is a memory read that redirects the program counter in the same cycle. The indirect jump provokes it with a nonzero rt field, and the bench checks that rt keeps its old value and that the instruction after the jump never stores.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

    localparam int XLEN    = 32;
    localparam int REG_NUM = 32;
    localparam int RIDX_W  = $clog2(REG_NUM);
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(REG_NUM - 1);

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JMP   = 6'h02;
    localparam logic [5:0] OPC_JLINK = 6'h03;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_JIND  = 6'h38;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;
    localparam logic [5:0] FN_LDX = 6'h30;

    typedef enum logic [1:0] {DST_RT = 2'b00, DST_RD = 2'b01, DST_LINK = 2'b10} dst_sel_e;
    typedef enum logic [1:0] {WB_ALU = 2'b00, WB_MEM = 2'b01, WB_PC4 = 2'b10} wb_sel_e;
    typedef enum logic [1:0] {NPC_SEQ = 2'b00, NPC_JUMP = 2'b01, NPC_MEM = 2'b10} npc_sel_e;
    typedef enum logic [1:0] {AC_ADD = 2'b00, AC_SUB = 2'b01, AC_FUNCT = 2'b10} alu_class_e;
    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

    typedef struct packed {
        logic [5:0]        opcode;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } instr_t;

    typedef struct packed {
        dst_sel_e   dst;
        wb_sel_e    wb;
        npc_sel_e   npc;
        alu_class_e aclass;
        logic       b_imm;
        logic       rf_we;
        logic       mem_re;
        logic       mem_we;
        logic       branch;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jump_target(input logic [XLEN-1:0] pc4,
                                                    input logic [25:0] idx);
        return {pc4[XLEN-1:XLEN-4], idx, 2'b00};
    endfunction

endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
    import scpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctrl,
    output alu_op_e    alu_op
);

    always_comb begin
        ctrl = '0;
        unique case (opcode)
            OPC_RTYPE: begin
                ctrl.dst   = DST_RD;
                ctrl.rf_we = 1'b1;
                if (funct == FN_LDX) begin
                    ctrl.wb     = WB_MEM;
                    ctrl.mem_re = 1'b1;
                    ctrl.aclass = AC_ADD;
                end else begin
                    ctrl.aclass = AC_FUNCT;
                end
            end
            OPC_LOAD: begin
                ctrl.wb     = WB_MEM;
                ctrl.b_imm  = 1'b1;
                ctrl.rf_we  = 1'b1;
                ctrl.mem_re = 1'b1;
            end
            OPC_STORE: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_we = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.aclass = AC_SUB;
            end
            OPC_JMP:   ctrl.npc = NPC_JUMP;
            OPC_JLINK: begin
                ctrl.dst   = DST_LINK;
                ctrl.wb    = WB_PC4;
                ctrl.rf_we = 1'b1;
                ctrl.npc   = NPC_JUMP;
            end
            OPC_JIND: begin
                ctrl.b_imm  = 1'b1;
                ctrl.mem_re = 1'b1;
                ctrl.npc    = NPC_MEM;
            end
            default: ctrl = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.aclass)
            AC_SUB:   alu_op = ALU_SUB;
            AC_FUNCT: begin
                unique case (funct)
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: alu_op = ALU_ADD;
                endcase
            end
            default:  alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
    import scpu_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int NREG = REG_NUM,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREG; i++) begin
            if (rst)
                regs[i] <= '0;
            else if (we && wa == AW'(i) && i != 0)
                regs[i] <= wd;
        end
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
    import scpu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = W'($signed(a) < $signed(b));
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scpu_core.sv
module scpu_core
    import scpu_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr,
    input  logic [XLEN-1:0] imem_data,
    output logic [XLEN-1:0] dmem_addr,
    output logic            dmem_re,
    output logic            dmem_we,
    output logic [XLEN-1:0] dmem_wdata,
    input  logic [XLEN-1:0] dmem_rdata
);

    instr_t            ins;
    ctrl_t             ctrl;
    alu_op_e           alu_op;
    logic [XLEN-1:0]   pc_q, pc4, br_tgt, j_tgt, npc;
    logic [XLEN-1:0]   imm_x, rs_val, rt_val, alu_b, alu_y, wr_data;
    logic [RIDX_W-1:0] rs_idx, wr_idx;
    logic              alu_zero, take_br;

    assign ins    = instr_t'(imem_data);
    assign rs_idx = ins.rs;
    assign imm_x  = sext16({ins.rd, ins.shamt, ins.funct});

    scpu_decode u_dec (
        .opcode (ins.opcode),
        .funct  (ins.funct),
        .ctrl   (ctrl),
        .alu_op (alu_op)
    );

    always_comb begin
        unique case (ctrl.dst)
            DST_RD:   wr_idx = ins.rd;
            DST_LINK: wr_idx = LINK_REG;
            default:  wr_idx = ins.rt;
        endcase
        unique case (ctrl.wb)
            WB_MEM:  wr_data = dmem_rdata;
            WB_PC4:  wr_data = pc4;
            default: wr_data = alu_y;
        endcase
    end

    scpu_regfile #(.W(XLEN), .NREG(REG_NUM)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (rs_idx),
        .ra_b (ins.rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (ctrl.rf_we),
        .wa   (wr_idx),
        .wd   (wr_data)
    );

    assign alu_b = ctrl.b_imm ? imm_x : rt_val;

    scpu_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    assign pc4     = pc_q + XLEN'(4);
    assign br_tgt  = pc4 + {imm_x[XLEN-3:0], 2'b00};
    assign j_tgt   = jump_target(pc4, {ins.rs, ins.rt, ins.rd, ins.shamt, ins.funct});
    assign take_br = ctrl.branch & alu_zero;

    always_comb begin
        unique case (ctrl.npc)
            NPC_JUMP: npc = j_tgt;
            NPC_MEM:  npc = dmem_rdata;
            default:  npc = take_br ? br_tgt : pc4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= npc;
    end

    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_re    = ctrl.mem_re;
    assign dmem_we    = ctrl.mem_we;
    assign dmem_wdata = rt_val;

endmodule

// File: rtl/scpu_core_chk.sv
module scpu_core_chk
    import scpu_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] instr,
    input logic            dre,
    input logic            dwe,
    input logic [XLEN-1:0] drdata,
    input logic [RIDX_W-1:0] rs_idx,
    input logic [XLEN-1:0] rs_val
);

    logic [5:0] op;
    assign op = instr[31:26];

    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(dre && dwe));

    p_zero_read_r10: assert property (@(posedge clk) disable iff (rst)
        (rs_idx == '0) |-> (rs_val == '0));

    p_store_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_STORE) |-> (dwe && !dre));

    p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_RTYPE) |=> (pc == $past(pc) + 32'd4));

    p_call_target_r7: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JLINK) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

    p_jump_target_r6: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JMP) |=> (pc[27:0] == {$past(instr[25:0]), 2'b00}));

    p_ind_jump_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OPC_JIND) |=> (pc == $past(drdata)));

    p_reset_pc_r1: assert property (@(posedge clk)
        rst |=> (pc == '0));

endmodule

bind scpu_core scpu_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pc     (imem_addr),
    .instr  (imem_data),
    .dre    (dmem_re),
    .dwe    (dmem_we),
    .drdata (dmem_rdata),
    .rs_idx (rs_idx),
    .rs_val (rs_val)
);

// File: tb/scpu_core_tb.sv
module scpu_core_tb;

    localparam int MEMW = 64;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_re, dmem_we;

    logic [31:0] imem [MEMW];
    logic [31:0] dmem [MEMW];

    int checks = 0;
    int errors = 0;
    int both_strobes = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    scpu_core u_dut (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_re    (dmem_re),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk)
        if (!rst && dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

    always @(negedge clk)
        if (!rst && dmem_re && dmem_we) both_strobes++;

    function automatic logic [31:0] e_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] e_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_j(logic [5:0] op, int word);
        return {op, 26'(word)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < MEMW; i++) begin
            imem[i] = 32'h0;
            dmem[i] = SENT;
        end
    endtask

    task automatic start();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear_mem();
        imem[0] = e_i(6'h23, 0, 1, 0);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc in reset", imem_addr, 32'h0);
        rst = 1'b0;
        chk("R1 pc after release", imem_addr, 32'h0);
        imem[0] = e_i(6'h2B, 0, 5, 32);
        imem[1] = e_i(6'h2B, 0, 31, 36);
        imem[2] = e_j(6'h02, 2);
        start();
        run(6);
        chk("R1 r5 cleared", dmem[8], 32'h0);
        chk("R1 r31 cleared", dmem[9], 32'h0);
    endtask

    task automatic t_alu();
        clear_mem();
        dmem[0] = 32'd7; dmem[1] = 32'd5;
        imem[0]  = e_i(6'h23, 0, 1, 0);
        imem[1]  = e_i(6'h23, 0, 2, 4);
        imem[2]  = e_r(1, 2, 3, 6'h20);
        imem[3]  = e_r(1, 2, 4, 6'h22);
        imem[4]  = e_r(1, 2, 5, 6'h24);
        imem[5]  = e_r(1, 2, 6, 6'h25);
        imem[6]  = e_r(2, 1, 7, 6'h2A);
        imem[7]  = e_r(1, 2, 8, 6'h2A);
        imem[8]  = e_i(6'h2B, 0, 3, 32);
        imem[9]  = e_i(6'h2B, 0, 4, 36);
        imem[10] = e_i(6'h2B, 0, 5, 40);
        imem[11] = e_i(6'h2B, 0, 6, 44);
        imem[12] = e_i(6'h2B, 0, 7, 48);
        imem[13] = e_i(6'h2B, 0, 8, 52);
        imem[14] = e_j(6'h02, 14);
        start();
        chk("R3 load read strobe", {31'b0, dmem_re}, 32'd1);
        chk("R11 load no write strobe", {31'b0, dmem_we}, 32'd0);
        run(8);
        chk("R4 store write strobe", {30'b0, dmem_we, dmem_re}, 32'd2);
        run(12);
        chk("R2 add", dmem[8], 32'd12);
        chk("R2 sub", dmem[9], 32'd2);
        chk("R2 and", dmem[10], 32'd5);
        chk("R2 or", dmem[11], 32'd7);
        chk("R2 slt true", dmem[12], 32'd1);
        chk("R2 slt false", dmem[13], 32'd0);
        chk("R3 load untouched word", dmem[0], 32'd7);
        chk("R6 self loop pc", imem_addr, 32'd56);
    endtask

    task automatic t_branch();
        clear_mem();
        dmem[0] = 32'd9; dmem[1] = 32'd9;
        imem[0] = e_i(6'h23, 0, 1, 0);
        imem[1] = e_i(6'h23, 0, 2, 4);
        imem[2] = e_i(6'h04, 1, 2, 1);
        imem[3] = e_i(6'h2B, 0, 1, 32);
        imem[4] = e_i(6'h2B, 0, 2, 36);
        imem[5] = e_i(6'h04, 1, 0, 1);
        imem[6] = e_i(6'h2B, 0, 1, 40);
        imem[7] = e_i(6'h04, 0, 0, -1);
        start();
        run(3);
        chk("R5 taken target", imem_addr, 32'd16);
        run(10);
        chk("R5 skipped store", dmem[8], SENT);
        chk("R5 landing store", dmem[9], 32'd9);
        chk("R5 not taken falls through", dmem[10], 32'd9);
        chk("R5 backward branch to self", imem_addr, 32'd28);
    endtask

    task automatic t_call();
        clear_mem();
        imem[0] = e_j(6'h03, 4);
        imem[1] = e_i(6'h2B, 0, 31, 32);
        imem[2] = e_j(6'h02, 2);
        imem[4] = e_i(6'h2B, 0, 31, 36);
        imem[5] = e_j(6'h02, 5);
        start();
        run(1);
        chk("R7 call target", imem_addr, 32'd16);
        run(6);
        chk("R7 link value", dmem[9], 32'd4);
        chk("R7 return slot skipped", dmem[8], SENT);
        chk("R6 jump holds", imem_addr, 32'd20);
    endtask

    task automatic t_ldx();
        clear_mem();
        dmem[0] = 32'd8; dmem[1] = 32'd12; dmem[2] = 32'd16;
        dmem[4] = 32'h0000_ABCD; dmem[5] = 32'h0000_1234; dmem[6] = 32'h77;
        imem[0] = e_i(6'h23, 0, 1, 0);
        imem[1] = e_i(6'h23, 0, 2, 4);
        imem[2] = e_r(1, 2, 3, 6'h30);
        imem[3] = e_i(6'h2B, 0, 3, 32);
        imem[4] = e_i(6'h23, 0, 4, 8);
        imem[5] = e_i(6'h23, 4, 4, 0);
        imem[6] = e_i(6'h2B, 0, 4, 36);
        imem[7] = e_r(2, 2, 2, 6'h30);
        imem[8] = e_i(6'h2B, 0, 2, 40);
        imem[9] = e_j(6'h02, 9);
        start();
        run(14);
        chk("R8 indexed load", dmem[8], 32'h1234);
        chk("R3 load into own base", dmem[9], 32'hABCD);
        chk("R8 indexed load rd=rs=rt", dmem[10], 32'h77);
    endtask

    task automatic t_jind();
        clear_mem();
        dmem[0] = 32'd8; dmem[3] = 32'd64;
        imem[0]  = e_i(6'h23, 0, 1, 0);
        imem[1]  = e_i(6'h38, 1, 1, 4);
        imem[2]  = e_i(6'h2B, 0, 1, 32);
        imem[16] = e_i(6'h2B, 0, 1, 36);
        imem[17] = e_j(6'h02, 17);
        start();
        run(1);
        chk("R9 jump read strobe", {31'b0, dmem_re}, 32'd1);
        run(1);
        chk("R9 pc from memory", imem_addr, 32'd64);
        run(5);
        chk("R9 next word skipped", dmem[8], SENT);
        chk("R9 rt not written", dmem[9], 32'd8);
        chk("R9 loop pc", imem_addr, 32'd68);
    endtask

    task automatic t_zero();
        clear_mem();
        dmem[0] = 32'h55;
        imem[0] = e_i(6'h23, 0, 1, 0);
        imem[1] = e_i(6'h23, 0, 0, 0);
        imem[2] = e_r(1, 1, 0, 6'h20);
        imem[3] = e_i(6'h2B, 0, 0, 32);
        imem[4] = e_r(0, 1, 2, 6'h20);
        imem[5] = e_i(6'h2B, 0, 2, 36);
        imem[6] = e_j(6'h02, 6);
        start();
        run(10);
        chk("R10 r0 after writes", dmem[8], 32'h0);
        chk("R10 r0 as operand", dmem[9], 32'h55);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_branch();
        t_call();
        t_ldx();
        t_jind();
        t_zero();
        chk("R11 strobes exclusive", 32'(both_strobes), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule